// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous SRAM that can switch between reads and writes on consecutive cycles with no idle cycle in between. Address, control and byte-lane enables are sampled at the rising clock edge. A read returns its word through an output register two edges after its address. A write takes its data from the data bus two edges after its address. As a result, the bus slot of every issued cycle falls at the same point in the pipeline, whether the cycle is a read or a write.

A cycle is either a load or an advance. A load takes a new external address. An advance steps a four-word burst from the last loaded address, in linear or interleaved order. The operation type and the selection of an advance are those of the last load. A clock enable freezes the whole pipeline. The output enable only gates whether the read data is driven, and it acts without waiting for a clock edge.

A read issued directly after a write to the same word returns the freshly written lanes. These lanes are merged over the older array contents. The model stores `2**ARRAY_AW` words and indexes them with the low address bits. Setting `ARRAY_AW=16` gives the full 65,536-word array.

Top module: `zt_sram`

## Requirements
- R1: A read load sampled at edge N (chip selected, `we_n`=1, `adv_ld`=0), with `cen_n` low at edges N, N+1 and N+2, drives the addressed word on `dq_out` with `dq_drive` high after edge N+2, provided `oe_n` is low.
- R2: A write load sampled at edge N stores the value on `din` at edge N+2 (counting only enabled edges). `dq_drive` is low after edge N+2, so the bus is free for that data.
- R3: `bw_n[i]` low at the address edge writes lane i (bits i*DW/4 up to (i+1)*DW/4-1). Lanes whose enable is high keep their old contents.
- R4: A load is selected only when `ce0_n`=0, `ce1`=1 and `ce2_n`=0. A deselected load writes nothing, and two edges later `dq_drive` is low.
- R5: With `cen_n` high, the clock edge is ignored. No pipeline, burst or output state changes, and inputs sampled on that edge have no effect.
- R6: `adv_ld`=1 advances the burst. The address is the last loaded address with only bits [1:0] replaced, and `we_n`, `addr` and the chip enables are ignored. The operation type and selection are taken from the last load.
- R7: With `lbo_n`=0, the k-th word of a burst has low bits (start+k) mod 4 (linear order). With `lbo_n`=1, it has low bits start XOR k (interleaved order).
- R8: `oe_n` high forces `dq_drive` low at once, without a clock edge. Taking `oe_n` low again drives the held read word without disturbing it.
- R9: A read issued on the cycle right after a write to the same address returns the written lanes merged over the previous word.
- R10: Reads and writes may alternate every cycle with no idle cycle. `dq_drive` is never high in a cycle whose bus slot belongs to a write.
- R11: Reset (`rst_n` low, asynchronous) empties the pipeline and drops `dq_drive`. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline and burst state |
| cen_n | input | 1 | Active-low clock enable |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| we_n | input | 1 | 1 read, 0 write (sampled on loads) |
| lbo_n | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| bw_n | input | 4 | Active-low byte-lane write enables |
| addr | input | AW | Word address |
| din | input | DW | Write data, sampled two edges after its address |
| dq_out | output | DW | Read data register |
| dq_drive | output | 1 | High when `dq_out` should drive the shared bus |

## Verification
The assertions check the following on every cycle:
- the read latency of two enabled edges;
- that no drive follows a write or deselected load;
- that a disabled edge leaves the output register untouched;
- that the output is quiet right after reset.

The merging of same-address forwarding, the byte-lane masks, and the two burst orders need known stored data, so only the bench scenarios can show them. The same holds for proving that a write or load offered on a disabled edge never reaches the array, and for the asynchronous output enable between edges.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int AW       = 16,
  parameter int DW       = 36,
  parameter int ARRAY_AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cen_n,
  input  logic          ce0_n,
  input  logic          ce1,
  input  logic          ce2_n,
  input  logic          adv_ld,
  input  logic          we_n,
  input  logic          lbo_n,
  input  logic          oe_n,
  input  logic [3:0]    bw_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dq_out,
  output logic          dq_drive
);
  localparam int LW    = DW / 4;
  localparam int DEPTH = 1 << ARRAY_AW;

  logic [DW-1:0] mem [DEPTH];

  logic [AW-1:0] base;
  logic [1:0]    cnt;
  logic          last_sel, last_wr;

  logic          s1_v, s1_wr;
  logic [AW-1:0] s1_a;
  logic [3:0]    s1_bw;

  logic          s2_v, s2_wr;
  logic [AW-1:0] s2_a;
  logic [3:0]    s2_bw;
  logic [DW-1:0] s2_rd;

  logic [DW-1:0] q_r;
  logic          q_v;

  wire           load    = !adv_ld;
  wire           sel_now = !ce0_n && ce1 && !ce2_n;
  wire [1:0]     cnt_nx  = load ? 2'd0 : cnt + 2'd1;
  wire [1:0]     low     = lbo_n ? (base[1:0] ^ cnt_nx) : (base[1:0] + cnt_nx);
  wire [AW-1:0]  ea      = load ? addr : {base[AW-1:2], low};
  wire           ev      = load ? sel_now : last_sel;
  wire           ew      = load ? !we_n : last_wr;

  logic [DW-1:0] wmask;
  always_comb begin
    wmask = '0;
    for (int i = 0; i < 4; i++) wmask[i*LW +: LW] = {LW{s2_bw[i]}};
  end

  wire           do_wr  = !cen_n && s2_v && s2_wr;
  wire           fwd    = s2_v && s2_wr && s1_v && !s1_wr && (s2_a == s1_a);
  wire [DW-1:0]  mem_rd = mem[s1_a[ARRAY_AW-1:0]];
  wire [DW-1:0]  rd_nx  = fwd ? ((mem_rd & ~wmask) | (din & wmask)) : mem_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0; cnt <= '0; last_sel <= 1'b0; last_wr <= 1'b0;
      s1_v <= 1'b0; s1_wr <= 1'b0; s1_a <= '0; s1_bw <= '0;
      s2_v <= 1'b0; s2_wr <= 1'b0; s2_a <= '0; s2_bw <= '0; s2_rd <= '0;
      q_r <= '0; q_v <= 1'b0;
    end else if (!cen_n) begin
      cnt <= cnt_nx;
      if (load) begin
        base     <= addr;
        last_sel <= sel_now;
        last_wr  <= !we_n;
      end
      s1_v  <= ev;
      s1_wr <= ew;
      s1_a  <= ea;
      s1_bw <= ~bw_n;
      s2_v  <= s1_v;
      s2_wr <= s1_wr;
      s2_a  <= s1_a;
      s2_bw <= s1_bw;
      s2_rd <= rd_nx;
      q_v   <= s2_v && !s2_wr;
      if (s2_v && !s2_wr) q_r <= s2_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && do_wr)
      mem[s2_a[ARRAY_AW-1:0]] <= (mem[s2_a[ARRAY_AW-1:0]] & ~wmask) | (din & wmask);
  end

  assign dq_out   = q_r;
  assign dq_drive = q_v && !oe_n;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cen_n,
  input logic          ce0_n,
  input logic          ce1,
  input logic          ce2_n,
  input logic          adv_ld,
  input logic          we_n,
  input logic          oe_n,
  input logic [DW-1:0] dq_out,
  input logic          dq_drive
);
  wire go      = rst_n && !cen_n;
  wire sel     = !ce0_n && ce1 && !ce2_n;
  wire rd_load = !adv_ld && we_n && sel;
  wire nr_load = !adv_ld && !(we_n && sel);

  // R1
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(go, 3) && $past(go, 2) && $past(go, 1) && $past(rd_load, 3) && !oe_n) |-> dq_drive);

  // R2 R4 R10
  quiet_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(go, 3) && $past(go, 2) && $past(go, 1) && $past(nr_load, 3)) |-> !dq_drive);

  // R5
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> $stable(dq_out));

  // R11
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !dq_drive);
endmodule

bind zt_sram zt_sram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
  .adv_ld(adv_ld), .we_n(we_n), .oe_n(oe_n), .dq_out(dq_out), .dq_drive(dq_drive)
);

// File: tb/tb_zt_sram.sv
`timescale 1ns/1ps
module tb_zt_sram;
  localparam int AW = 16;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cen_n = 1'b0, ce0_n = 1'b0, ce1 = 1'b0, ce2_n = 1'b0;
  logic adv_ld = 1'b0, we_n = 1'b1, lbo_n = 1'b0, oe_n = 1'b0;
  logic [3:0] bw_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dq_out;
  logic dq_drive;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  zt_sram #(.AW(AW), .DW(DW), .ARRAY_AW(10)) dut (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
    .adv_ld(adv_ld), .we_n(we_n), .lbo_n(lbo_n), .oe_n(oe_n), .bw_n(bw_n),
    .addr(addr), .din(din), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  always #2.5 clk = ~clk;

  localparam logic [35:0] X  = 36'h0;
  localparam logic [35:0] D0 = 36'h123456789, D1 = 36'hABCDEF012;
  localparam logic [35:0] D2 = 36'h0F0F0F0F0, D3 = 36'h555555555;
  localparam logic [35:0] E0 = 36'h111111111, E1 = 36'h222222222;
  localparam logic [35:0] E2 = 36'h333333333, E3 = 36'h444444444;
  localparam logic [35:0] M02 = 36'h007FC01FF;  // lanes 0 and 2
  localparam logic [35:0] DM = (D1 & ~M02) | (D3 & M02);
  localparam logic [35:0] ONES = 36'hFFFFFFFFF;

  function automatic logic [89:0] mk(input logic c, input logic s, input logic a,
      input logic w, input logic l, input logic [3:0] b, input logic [7:0] ad,
      input logic [35:0] di, input logic dv, input logic [35:0] qq);
    return {c, s, a, w, l, b, ad, di, dv, qq};
  endfunction

  // fields: cen_n, sel, adv, write, lbo_n, bw_n, addr, din, exp drive, exp q
  localparam int N = 39;
  localparam logic [89:0] TBL [N] = '{
    mk(0,1,0,1,0,4'h0,8'h10,X ,0,X ),  // 0  write 10
    mk(0,1,0,1,0,4'h0,8'h11,X ,0,X ),  // 1  write 11
    mk(0,1,0,0,0,4'h0,8'h10,D0,0,X ),  // 2  read 10, data for 0 (R2)
    mk(0,1,0,1,0,4'h0,8'h12,D1,0,X ),  // 3  write 12, data for 1 (R10)
    mk(0,1,0,0,0,4'h0,8'h11,X ,1,D0),  // 4  R1
    mk(0,1,0,0,0,4'h0,8'h12,D2,0,X ),  // 5  R10 no drive in write slot
    mk(0,1,0,1,0,4'hA,8'h11,X ,1,D1),  // 6  partial write lanes 0,2 (R3)
    mk(0,1,0,0,0,4'h0,8'h11,X ,1,D2),  // 7  read right after write (R9)
    mk(0,0,0,0,0,4'h0,8'h00,D3,0,X ),  // 8  deselect (R4)
    mk(0,0,0,0,0,4'h0,8'h00,X ,1,DM),  // 9  R9 R3 merged word
    mk(0,0,0,0,0,4'h0,8'h00,X ,0,X ),  // 10
    mk(0,1,0,1,0,4'h0,8'h20,X ,0,X ),  // 11 burst write load 20
    mk(0,1,1,0,0,4'h0,8'hFF,X ,0,X ),  // 12 advance, we_n/addr ignored (R6)
    mk(0,1,1,0,0,4'h0,8'hFF,E0,0,X ),  // 13
    mk(0,1,1,0,0,4'h0,8'hFF,E1,0,X ),  // 14
    mk(0,1,0,0,0,4'h0,8'h22,E2,0,X ),  // 15 linear read from 22 (R7)
    mk(0,0,1,1,0,4'h0,8'hFF,E3,0,X ),  // 16 advance ignores ce1 (R6)
    mk(0,1,1,1,0,4'h0,8'hFF,X ,1,E2),  // 17
    mk(0,1,1,1,0,4'h0,8'hFF,X ,1,E3),  // 18
    mk(0,0,0,0,0,4'h0,8'h00,X ,1,E0),  // 19 R7 linear wrap
    mk(0,0,0,0,0,4'h0,8'h00,X ,1,E1),  // 20
    mk(0,1,0,0,1,4'h0,8'h21,X ,0,X ),  // 21 interleaved read from 21
    mk(0,1,1,0,1,4'h0,8'hFF,X ,0,X ),  // 22
    mk(0,1,1,0,1,4'h0,8'hFF,X ,1,E1),  // 23
    mk(0,1,1,0,1,4'h0,8'hFF,X ,1,E0),  // 24 R7 start xor 1
    mk(0,0,0,0,0,4'h0,8'h00,X ,1,E3),  // 25 R7 start xor 2
    mk(0,0,0,0,0,4'h0,8'h00,X ,1,E2),  // 26 R7 start xor 3
    mk(0,0,0,0,0,4'h0,8'h00,X ,0,X ),  // 27
    mk(0,1,0,0,0,4'h0,8'h10,X ,0,X ),  // 28 read 10
    mk(1,1,0,1,0,4'h0,8'h11,ONES,0,X), // 29 R5 edge ignored
    mk(0,0,0,0,0,4'h0,8'h00,X ,0,X ),  // 30 R5 one edge late
    mk(0,0,0,0,0,4'h0,8'h00,X ,1,D0),  // 31
    mk(0,0,0,0,0,4'h0,8'h00,X ,0,X ),  // 32
    mk(0,1,0,0,0,4'h0,8'h12,X ,0,X ),  // 33 read 12
    mk(0,0,0,0,0,4'h0,8'h00,X ,0,X ),  // 34
    mk(0,0,0,0,0,4'h0,8'h00,X ,1,D2),  // 35
    mk(1,1,0,1,0,4'h0,8'h12,ONES,1,D2),// 36 R5 output held
    mk(1,1,0,1,0,4'h0,8'h12,ONES,1,D2),// 37 R5
    mk(0,0,0,0,0,4'h0,8'h00,X ,0,X )   // 38
  };

  task automatic chk(input string tag, input logic gd, input logic ed,
                     input logic [DW-1:0] gq, input logic [DW-1:0] eq);
    checks++;
    if (gd !== ed || (ed && gq !== eq)) begin
      failures++;
      $display("FAIL %s actual drive=%0b q=%h expected drive=%0b q=%h", tag, gd, gq, ed, eq);
    end
  endtask

  task automatic drive(input logic c, input logic s, input logic a, input logic w,
                       input logic l, input logic [3:0] b, input logic [AW-1:0] ad,
                       input logic [DW-1:0] di);
    cen_n = c; ce0_n = 1'b0; ce1 = s; ce2_n = 1'b0; adv_ld = a; we_n = !w;
    lbo_n = l; bw_n = b; addr = ad; din = di;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 4'hF, '0, '0);
    step();
  endtask

  task automatic read_word(input logic [AW-1:0] a);
    drive(0, 1, 0, 0, 0, 4'hF, a, '0);
    step();
    idle();
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    drive(0, 0, 0, 0, 0, 4'hF, '0, '0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R11 reset state", dq_drive, 1'b0, dq_out, X);

    for (int i = 0; i < N; i++) begin
      logic [89:0] v;
      v = TBL[i];
      drive(v[89], v[88], v[87], v[86], v[85], v[84:81], {8'h00, v[80:73]}, v[72:37]);
      step();
      chk($sformatf("R1 R5 R6 R7 R9 vector %0d", i), dq_drive, v[36], dq_out, v[35:0]);
    end

    // R5: writes offered on disabled edges left 12 and 11 untouched
    read_word(16'h0012);
    chk("R5 held edge wrote nothing to 12", dq_drive, 1'b1, dq_out, D2);
    // R8: output enable without a clock edge
    oe_n = 1'b1; #1;
    chk("R8 oe_n high drops drive", dq_drive, 1'b0, dq_out, D2);
    oe_n = 1'b0; #1;
    chk("R8 oe_n low restores word", dq_drive, 1'b1, dq_out, D2);

    // R4: each chip enable alone blocks a write and a read
    for (int k = 0; k < 3; k++) begin
      drive(0, 1, 0, 1, 0, 4'h0, 16'h0010, '0);
      if (k == 0) ce0_n = 1'b1;
      if (k == 1) ce1 = 1'b0;
      if (k == 2) ce2_n = 1'b1;
      step();
      idle();
      drive(0, 0, 0, 0, 0, 4'h0, '0, ONES);
      step();
      chk($sformatf("R4 deselected write, enable %0d", k), dq_drive, 1'b0, dq_out, X);
      drive(0, 1, 0, 0, 0, 4'hF, 16'h0010, '0);
      if (k == 0) ce0_n = 1'b1;
      if (k == 1) ce1 = 1'b0;
      if (k == 2) ce2_n = 1'b1;
      step();
      idle();
      idle();
      chk($sformatf("R4 deselected read, enable %0d", k), dq_drive, 1'b0, dq_out, X);
      read_word(16'h0010);
      chk($sformatf("R4 word kept, enable %0d", k), dq_drive, 1'b1, dq_out, D0);
    end

    // R6: advance after a deselected load stays deselected
    idle();
    drive(0, 1, 1, 0, 0, 4'hF, 16'h0010, '0);
    step();
    idle();
    idle();
    chk("R6 advance inherits deselect", dq_drive, 1'b0, dq_out, X);

    // R3: single-lane write to lane 0 of address 12
    drive(0, 1, 0, 1, 0, 4'hE, 16'h0012, '0);
    step();
    idle();
    drive(0, 0, 0, 0, 0, 4'hF, '0, ONES);
    step();
    read_word(16'h0012);
    chk("R3 lane 0 only", dq_drive, 1'b1, dq_out, (D2 & ~36'h1FF) | 36'h1FF);

    // R11: reset mid-read empties pipeline, memory kept
    drive(0, 1, 0, 0, 0, 4'hF, 16'h0011, '0);
    step();
    idle();
    rst_n = 1'b0; #1;
    chk("R11 async reset drops drive", dq_drive, 1'b0, dq_out, X);
    step();
    rst_n = 1'b1;
    idle();
    idle();
    chk("R11 pipeline empty after reset", dq_drive, 1'b0, dq_out, X);
    read_word(16'h0011);
    chk("R11 memory kept through reset", dq_drive, 1'b1, dq_out, DM);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule